// File: doc/BRIEF.md
# Masked Majority Trigger Combiner

This block folds a vector of per-channel self-trigger bits into a single trigger line. The vector first passes an enable mask, so that each channel can be switched out of the decision. An optional pair stage then merges each adjacent channel pair by OR or AND and writes the merged bit into both positions of the pair. A main stage decides from the resulting vector by OR, by AND, or by a majority: the number of set bits is compared against a programmable level.

The decision feeds an output shaper. The shaper either follows the decision cycle by cycle or turns each rising edge into a gate of programmable width. The gate can be retriggerable or non-retriggerable. The final line can be inverted. All configuration inputs are static levels that the surrounding logic holds. The block is used wherever a set of channel triggers must be combined into one coincidence, multiplicity or veto condition.

Top module: `trig_combiner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, with invert clear, the output is low and no gate is open.
- R2: A channel whose mask bit is 0 is treated as inactive in every pair and main mode, whatever its input does.
- R3: The pair mode (2 bits) selects the pair stage. 1 = OR and 2 = AND: channels 2k and 2k+1 both carry the OR (or AND) of the two masked inputs. 0 and 3 = none: the masked vector passes through unchanged.
- R4: A merged pair counts as two set bits in the majority sum.
- R5: The main mode (2 bits) selects the decision. 0 = OR of the pair-stage vector. 1 = AND over the enabled positions. 2 and 3 = majority. AND with an all-zero mask is always false.
- R6: The majority decision is true in each cycle in which the count of set pair-stage bits is at least the level. A level of 0 is always true. The count is re-evaluated every cycle with no memory.
- R7: With a gate width of 0 the output is linear. A trigger vector presented in the cycle before clock edge k appears at the output just after edge k+2.
- R8: With a nonzero width W, a rising edge of the decision opens a gate that is high for exactly W cycles. It starts with the same latency as the linear output.
- R9: With retrigger clear, rising edges of the decision that arrive while the gate is open are ignored, and the gate closes W cycles after it opened.
- R10: With retrigger set, a rising edge while the gate is open restarts the full W-cycle window.
- R11: With invert set, the output is the complement of the direct output, in both linear and gated modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | N_CH | Per-channel self-trigger bits |
| cfg_mask | input | N_CH | Channel enable mask, 1 = enabled |
| cfg_pair | input | 2 | Pair stage mode: 0/3 none, 1 OR, 2 AND |
| cfg_main | input | 2 | Main mode: 0 OR, 1 AND, 2/3 majority |
| cfg_level | input | CNT_W | Majority level |
| cfg_width | input | GATE_W | Gate width in cycles, 0 = linear |
| cfg_retrig | input | 1 | 1 = gate is retriggerable |
| cfg_invert | input | 1 | 1 = invert the output |
| trig_out | output | 1 | Combined trigger |

## Verification
The embedded assertions check two relations on every cycle. The first is that the registered AND and count results stay consistent with the registered OR. The second is that the linear output follows the decision with one register of delay. They also check that an open non-retriggerable gate only counts down, and that a rising edge always opens a closed gate. Other properties can only be shown by the bench's scenarios against its behavioural model: pair duplication counting twice in the majority, masked channels having no effect, the exact gate length, restarts under retrigger, and the zero-mask AND case.

// File: rtl/trig_comb_pkg.sv
`timescale 1ns/1ps
package trig_comb_pkg;
   typedef enum logic [1:0] {
      PAIR_THRU  = 2'd0,
      PAIR_OR    = 2'd1,
      PAIR_AND   = 2'd2,
      PAIR_THRU3 = 2'd3
   } pair_mode_e;

   typedef enum logic [1:0] {
      MAIN_OR   = 2'd0,
      MAIN_AND  = 2'd1,
      MAIN_MAJ  = 2'd2,
      MAIN_MAJ3 = 2'd3
   } main_mode_e;
endpackage

// File: rtl/trig_pair_stage.sv
`timescale 1ns/1ps
module trig_pair_stage
   import trig_comb_pkg::*;
#(
   parameter int N_CH = 16
) (
   input  logic [N_CH-1:0] raw_i,
   input  logic [N_CH-1:0] mask_i,
   input  logic [1:0]      mode_i,
   output logic [N_CH-1:0] vec_o
);
   localparam int N_PAIR = N_CH / 2;

   logic [N_CH-1:0] masked;
   pair_mode_e      mode;

   assign masked = raw_i & mask_i;
   assign mode   = pair_mode_e'(mode_i);

   for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
      logic lo, hi, merged;
      assign lo = masked[2*k];
      assign hi = masked[2*k+1];
      always_comb begin
         unique case (mode)
            PAIR_OR:  merged = lo | hi;
            PAIR_AND: merged = lo & hi;
            default:  merged = 1'b0;
         endcase
      end
      assign vec_o[2*k]   = (mode == PAIR_OR || mode == PAIR_AND) ? merged : lo;
      assign vec_o[2*k+1] = (mode == PAIR_OR || mode == PAIR_AND) ? merged : hi;
   end
endmodule

// File: rtl/trig_main_stage.sv
`timescale 1ns/1ps
module trig_main_stage
   import trig_comb_pkg::*;
#(
   parameter int N_CH  = 16,
   parameter int CNT_W = $clog2(N_CH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CH-1:0]  vec_i,
   input  logic [N_CH-1:0]  mask_i,
   input  logic [1:0]       mode_i,
   input  logic [CNT_W-1:0] level_i,
   output logic             hit_o
);
   logic [N_CH-1:0]  vec_q;
   logic [CNT_W-1:0] cnt_d, cnt_q;
   logic             or_q, and_q;
   main_mode_e       mode;

   assign mode = main_mode_e'(mode_i);

   always_comb begin
      cnt_d = '0;
      for (int i = 0; i < N_CH; i++) cnt_d = cnt_d + CNT_W'(vec_i[i] ? 1 : 0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q <= '0;
         cnt_q <= '0;
         or_q  <= 1'b0;
         and_q <= 1'b0;
      end else begin
         vec_q <= vec_i;
         cnt_q <= cnt_d;
         or_q  <= |vec_q;
         and_q <= (|mask_i) & (&(vec_q | ~mask_i));
      end
   end

   // count and OR take different paths: vec_i vs vec_q, one cycle apart
   logic [CNT_W-1:0] cnt_s;
   always_ff @(posedge clk) begin
      if (!rst_n) cnt_s <= '0;
      else        cnt_s <= cnt_q;
   end

   always_comb begin
      unique case (mode)
         MAIN_OR:  hit_o = or_q;
         MAIN_AND: hit_o = and_q;
         default:  hit_o = (cnt_s >= level_i);
      endcase
   end

   // R5: the enabled-AND result can only be true when some bit was set
   a_r5_and_implies_or: assert property (@(posedge clk) disable iff (!rst_n)
      and_q |-> or_q);
   // R6: the popcount path and the OR path agree on an empty vector
   a_r6_count_matches_or: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_s != '0) == or_q);
endmodule

// File: rtl/trig_gate_shaper.sv
`timescale 1ns/1ps
module trig_gate_shaper #(
   parameter int GATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   input  logic [GATE_W-1:0] width_i,
   input  logic              retrig_i,
   input  logic              invert_i,
   output logic              out_o
);
   logic              hit_d, lin_q, rise;
   logic [GATE_W-1:0] cnt_q;

   assign rise = hit_i & ~hit_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_d <= 1'b0;
         lin_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         hit_d <= hit_i;
         lin_q <= hit_i;
         if (rise && (retrig_i || cnt_q == '0)) cnt_q <= width_i;
         else if (cnt_q != '0)                  cnt_q <= cnt_q - 1'b1;
      end
   end

   assign out_o = ((width_i == '0) ? lin_q : (cnt_q != '0)) ^ invert_i;

   // R9: an open non-retriggerable gate only counts down
   a_r9_nonretrig_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (!retrig_i && cnt_q != '0) |=> (cnt_q == GATE_W'($past(cnt_q) - 1'b1)));
   // R8: a rising edge on a closed gate with nonzero width opens it
   a_r8_gate_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && cnt_q == '0 && width_i != '0) |=> (cnt_q != '0));
   // R7: linear output follows the decision by one register
   a_r7_linear_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (width_i == '0) |=> (width_i != '0 || out_o == ($past(hit_i) ^ invert_i)));
endmodule

// File: rtl/trig_combiner.sv
`timescale 1ns/1ps
module trig_combiner #(
   parameter int N_CH   = 16,
   parameter int GATE_W = 8,
   localparam int CNT_W = $clog2(N_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   trig_in,
   input  logic [N_CH-1:0]   cfg_mask,
   input  logic [1:0]        cfg_pair,
   input  logic [1:0]        cfg_main,
   input  logic [CNT_W-1:0]  cfg_level,
   input  logic [GATE_W-1:0] cfg_width,
   input  logic              cfg_retrig,
   input  logic              cfg_invert,
   output logic              trig_out
);
   if (N_CH < 2 || (N_CH % 2) != 0) begin : g_bad_nch
      $error("trig_combiner: N_CH must be even and at least 2");
   end
   if (GATE_W < 1) begin : g_bad_gw
      $error("trig_combiner: GATE_W must be at least 1");
   end

   logic [N_CH-1:0] pair_vec;
   logic            hit;

   trig_pair_stage #(.N_CH(N_CH)) u_pair (
      .raw_i  (trig_in),
      .mask_i (cfg_mask),
      .mode_i (cfg_pair),
      .vec_o  (pair_vec)
   );

   trig_main_stage #(.N_CH(N_CH), .CNT_W(CNT_W)) u_main (
      .clk     (clk),
      .rst_n   (rst_n),
      .vec_i   (pair_vec),
      .mask_i  (cfg_mask),
      .mode_i  (cfg_main),
      .level_i (cfg_level),
      .hit_o   (hit)
   );

   trig_gate_shaper #(.GATE_W(GATE_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_i    (hit),
      .width_i  (cfg_width),
      .retrig_i (cfg_retrig),
      .invert_i (cfg_invert),
      .out_o    (trig_out)
   );
endmodule

// File: tb/trig_combiner_tb.sv
`timescale 1ns/1ps
module trig_combiner_tb;
   localparam int N  = 16;
   localparam int GW = 8;
   localparam int CW = $clog2(N + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  trig_in = '0;
   logic [N-1:0]  cfg_mask = '1;
   logic [1:0]    cfg_pair = 2'd0;
   logic [1:0]    cfg_main = 2'd0;
   logic [CW-1:0] cfg_level = '0;
   logic [GW-1:0] cfg_width = '0;
   logic          cfg_retrig = 1'b0;
   logic          cfg_invert = 1'b0;
   logic          trig_out;

   int    n_chk = 0, n_bad = 0;
   bit    done = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   trig_combiner #(.N_CH(N), .GATE_W(GW)) u_dut (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_mask(cfg_mask),
      .cfg_pair(cfg_pair), .cfg_main(cfg_main), .cfg_level(cfg_level),
      .cfg_width(cfg_width), .cfg_retrig(cfg_retrig), .cfg_invert(cfg_invert),
      .trig_out(trig_out));

   // behavioural reference model
   int m_vec1[N];
   int m_cnt2, m_or2, m_and2;
   int m_hit, m_hitd, m_lin, m_gate;

   function automatic int model_hit();
      if (cfg_main == 2'd0) return m_or2;
      if (cfg_main == 2'd1) return m_and2;
      return (m_cnt2 >= int'(cfg_level)) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_vec1[i]) m_vec1[i] = 0;
         m_cnt2 = 0; m_or2 = 0; m_and2 = 0;
         m_hitd = 0; m_lin = 0; m_gate = 0;
      end else begin
         int s, any_en, all_en;
         int masked[N];
         m_hit = model_hit();
         if (m_hit == 1 && m_hitd == 0 && (cfg_retrig || m_gate == 0))
            m_gate = int'(cfg_width);
         else if (m_gate > 0) m_gate = m_gate - 1;
         m_lin  = m_hit;
         m_hitd = m_hit;
         s = 0; any_en = 0; all_en = 1;
         for (int i = 0; i < N; i++) begin
            s += m_vec1[i];
            if (cfg_mask[i]) begin
               any_en = 1;
               if (m_vec1[i] == 0) all_en = 0;
            end
         end
         m_cnt2 = s;
         m_or2  = (s > 0) ? 1 : 0;
         m_and2 = (any_en && all_en) ? 1 : 0;
         for (int i = 0; i < N; i++) masked[i] = (trig_in[i] && cfg_mask[i]) ? 1 : 0;
         for (int k = 0; k < N / 2; k++) begin
            int a, b;
            a = masked[2*k]; b = masked[2*k+1];
            if (cfg_pair == 2'd1) begin
               m_vec1[2*k] = a | b; m_vec1[2*k+1] = a | b;
            end else if (cfg_pair == 2'd2) begin
               m_vec1[2*k] = a & b; m_vec1[2*k+1] = a & b;
            end else begin
               m_vec1[2*k] = a; m_vec1[2*k+1] = b;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         int exp_v;
         exp_v = (cfg_width == '0) ? m_lin : ((m_gate != 0) ? 1 : 0);
         if (cfg_invert) exp_v = 1 - exp_v;
         n_chk++;
         if (int'(trig_out) != exp_v) begin
            n_bad++;
            $display("FAIL %s t=%0t trig_out=%0d expected=%0d", cur_req, $time, trig_out, exp_v);
         end
      end
   end

   task automatic step(input logic [N-1:0] v);
      @(posedge clk); #1;
      trig_in = v;
   endtask

   task automatic rand_run(input int cycles, input int dens);
      for (int c = 0; c < cycles; c++) begin
         logic [N-1:0] v;
         v = N'($urandom);
         for (int d = 0; d < dens; d++) v = v & N'($urandom);
         step(v);
      end
   endtask

   task automatic cfg(input logic [N-1:0] mk, input logic [1:0] pr, input logic [1:0] mn,
                      input int lvl, input int wd, input logic rt, input logic iv);
      @(posedge clk); #1;
      cfg_mask = mk; cfg_pair = pr; cfg_main = mn; cfg_level = CW'(lvl);
      cfg_width = GW'(wd); cfg_retrig = rt; cfg_invert = iv;
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      cur_req = "R1";
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      step('0); step('0);
      // R7: linear single pulses through OR
      cur_req = "R7";
      cfg('1, 2'd0, 2'd0, 0, 0, 1'b0, 1'b0);
      for (int i = 0; i < N; i++) begin step(N'(1) << i); step('0); step('0); end
      rand_run(200, 2);
      // R2: partial mask across modes
      cur_req = "R2";
      for (int mn = 0; mn < 3; mn++) begin
         cfg(16'h0F0F, 2'd0, 2'(mn), 3, 0, 1'b0, 1'b0);
         step(16'hF0F0); step(16'hF0F0); step('0);
         rand_run(200, 1);
      end
      // R3: pair OR / AND / pass-through mode 3
      cur_req = "R3";
      for (int pr = 1; pr < 4; pr++) begin
         cfg('1, 2'(pr), 2'd1, 0, 0, 1'b0, 1'b0);
         step(16'h5555); step(16'hAAAA); step('1); step('0);
         cfg('1, 2'(pr), 2'd2, 6, 0, 1'b0, 1'b0);
         rand_run(200, 1);
      end
      // R4: one merged pair reaches level 2
      cur_req = "R4";
      cfg('1, 2'd1, 2'd2, 2, 0, 1'b0, 1'b0);
      step(16'h0001); step('0); step('0);
      cfg('1, 2'd0, 2'd2, 2, 0, 1'b0, 1'b0);
      step(16'h0001); step('0); step('0);
      cfg('1, 2'd1, 2'd3, 4, 0, 1'b0, 1'b0);
      rand_run(200, 2);
      // R5: AND modes including zero mask
      cur_req = "R5";
      cfg('0, 2'd0, 2'd1, 0, 0, 1'b0, 1'b0);
      for (int c = 0; c < 10; c++) step('1);
      cfg(16'h00FF, 2'd0, 2'd1, 0, 0, 1'b0, 1'b0);
      step(16'h00FF); step(16'hFF7F); step(16'hFFFF); step('0);
      rand_run(100, 0);
      // R6: majority boundaries
      cur_req = "R6";
      cfg('1, 2'd0, 2'd2, 0, 0, 1'b0, 1'b0);
      rand_run(50, 2);
      cfg('1, 2'd0, 2'd2, N, 0, 1'b0, 1'b0);
      step(16'hFFFE); step('1); step('0);
      for (int l = 1; l < N; l += 3) begin
         cfg('1, 2'd0, 2'd2, l, 0, 1'b0, 1'b0);
         rand_run(100, 0);
      end
      // R8: fixed-length gate
      cur_req = "R8";
      cfg('1, 2'd0, 2'd0, 0, 5, 1'b0, 1'b0);
      for (int c = 0; c < 10; c++) begin step(16'h0010); repeat (9) step('0); end
      cfg('1, 2'd0, 2'd0, 0, 1, 1'b0, 1'b0);
      rand_run(150, 3);
      // R9: non-retriggerable with dense edges
      cur_req = "R9";
      cfg('1, 2'd0, 2'd0, 0, 7, 1'b0, 1'b0);
      for (int c = 0; c < 20; c++) begin step(16'h0001); step('0); end
      rand_run(300, 3);
      // R10: retriggerable
      cur_req = "R10";
      cfg('1, 2'd0, 2'd0, 0, 7, 1'b1, 1'b0);
      for (int c = 0; c < 20; c++) begin step(16'h0001); step('0); step('0); end
      repeat (12) step('0);
      rand_run(300, 3);
      // R11: inversion, linear and gated
      cur_req = "R11";
      cfg('1, 2'd0, 2'd0, 0, 0, 1'b0, 1'b1);
      rand_run(100, 2);
      cfg('1, 2'd2, 2'd2, 4, 3, 1'b1, 1'b1);
      rand_run(200, 0);
      repeat (10) step('0);
      finish_run();
   end
endmodule